// File: doc/BRIEF.md
# Configuration Stream Loader Sequencer

This block brings a device from reset, or from a program request, to an operating state. Every load cycle runs in a fixed order:

1. Clear the whole configuration memory model, one address per clock.
2. Sample the mode pins once. These pins select master or slave, serial or parallel, and the bus width.
3. Parse an incoming 32-bit word stream.
4. Run a start-up sequence that ends with `done` high.

The stream is consumed through a valid/ready handshake. A word moves only in a cycle where `s_valid` and `s_ready` are both high. The sender must hold `s_data` stable while `s_valid` is high and `s_ready` is low. The block lowers `s_ready` in every phase where it cannot take a word: clearing, mode sampling, start-up, error, and any cycle in which `prog_n` is low.

Stream layout:

1. The width-detect pattern `0x000000BB`. Any words before it are ignored.
2. The synchronization word `0xAA995566`. Any words before it are ignored.
3. The device identifier.
4. A word count N.
5. N data words. These are written to memory addresses 0 to N-1.
6. A checksum word.

The checksum is CRC-32 with polynomial `0x1EDC6F41`, initial value `0xFFFFFFFF`, no reflection and no final inversion. It is fed MSB first, one word at a time. It covers the identifier, the count and the data words.

If the checksum matches, the start-up sequence runs. It releases the internal flip-flop reset. Each wait below is used only when its enable input is high:

- wait for PLL lock;
- wait for impedance match.

It then enables the output drivers and finally raises `done`.

Top module: `cfg_loader`

## Requirements
- R1: After reset, or while `prog_n` is low and then after it rises, `mem_clr` is high for DEPTH consecutive cycles with `mem_addr` counting 0 to DEPTH-1. `done`, `err`, `out_en` and `ff_release` are low throughout.
- R2: `cfg_mode` takes `mode_pins` in the single cycle after clearing ends. It holds that value until the next load cycle.
- R3: Accepted words other than `0x000000BB` are ignored while the block waits for the width pattern. Words other than `0xAA995566` are ignored while it waits for the sync word.
- R4: If the identifier word differs from parameter DEVICE_ID, `err` goes high. It stays high, with `done` low, until `prog_n` is driven low.
- R5: Each accepted data word is written with `mem_we` high, to addresses 0, 1, 2, ... in arrival order, one write per handshake.
- R6: If the checksum word differs from the CRC-32 defined above, `err` is set and held, and `done` stays low.
- R7: A count word greater than DEPTH sets `err`. A count of zero goes straight to the checksum.
- R8: Start-up order is fixed: `ff_release` rises first, then `out_en`, then `done`. Each step takes at least one clock, and the outputs stay high once raised.
- R9: With `wait_lock_en` high, start-up holds before `out_en` until `pll_lock` is high. With `wait_match_en` high, it holds until `imp_match` is high. With the enable low, that wait is skipped.
- R10: `prog_n` low at any time restarts the cycle. It clears `err`, `done`, `out_en` and `ff_release` at the next edge, and forces `s_ready` and `mem_we` low in the same cycle.
- R11: `s_ready` is high only in the parsing phases. A word is taken only when `s_valid` and `s_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| prog_n | input | 1 | Active-low program request |
| mode_pins | input | 3 | Configuration mode selection |
| wait_lock_en | input | 1 | Start-up waits for `pll_lock` |
| wait_match_en | input | 1 | Start-up waits for `imp_match` |
| pll_lock | input | 1 | PLL lock status |
| imp_match | input | 1 | Impedance match status |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Block accepts a stream word |
| mem_clr | output | 1 | Clear strobe for `mem_addr` |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| mem_addr | output | AW (4) | Memory address |
| mem_wdata | output | 32 | Memory write data |
| cfg_mode | output | 3 | Sampled mode |
| ff_release | output | 1 | Internal flip-flop reset released |
| out_en | output | 1 | Output drivers enabled |
| done | output | 1 | Configuration complete |
| err | output | 1 | Sticky load error |

## Verification
Two functions can fall in the same cycle: a program request and a stream handshake, in particular a data write. The bench provokes this by lowering `prog_n` in the very cycle it presents a valid data word in mid-frame. It then checks that `s_ready` and `mem_we` are both low in that cycle and that the following edge restarts clearing. A behavioural cycle model compares every output on every clock. Its expected values come from its own phase counter and CRC routine. After the interrupted frame, a full reload must still reach `done`.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int          WORD_W    = 32;
  localparam logic [31:0] WIDTH_PAT = 32'h0000_00BB;
  localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
  localparam logic [31:0] CRC_POLY  = 32'h1EDC_6F41;
  localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;

  typedef enum logic [3:0] {
    P_CLR, P_MODE, P_WID, P_SYNC, P_ID, P_LEN, P_DATA, P_CRC, P_BOOT, P_ERR
  } parse_t;

  typedef enum logic [2:0] {
    SU_IDLE, SU_REL, SU_WLOCK, SU_WMATCH, SU_OE, SU_DONE
  } boot_t;
endpackage

// File: rtl/cfg_crc_step.sv
module cfg_crc_step #(
  parameter int          WW   = 32,
  parameter logic [31:0] POLY = 32'h1EDC_6F41
) (
  input  logic [31:0]   crc_in,
  input  logic [WW-1:0] word,
  output logic [31:0]   crc_out
);
  // One word folded MSB first, one polynomial step per bit.
  always_comb begin
    logic [31:0] c;
    logic fb;
    c = crc_in;
    for (int i = WW - 1; i >= 0; i--) begin
      fb = c[31] ^ word[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_out = c;
  end
endmodule

// File: rtl/cfg_startup.sv
module cfg_startup
  import cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic go,
  input  logic wait_lock_en,
  input  logic wait_match_en,
  input  logic pll_lock,
  input  logic imp_match,
  output logic ff_release,
  output logic out_en,
  output logic done
);
  boot_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SU_IDLE;
    else if (restart) st <= SU_IDLE;
    else begin
      case (st)
        SU_IDLE:   if (go) st <= SU_REL;
        SU_REL:    st <= SU_WLOCK;
        SU_WLOCK:  if (!wait_lock_en || pll_lock) st <= SU_WMATCH;
        SU_WMATCH: if (!wait_match_en || imp_match) st <= SU_OE;
        SU_OE:     st <= SU_DONE;
        SU_DONE:   st <= SU_DONE;
        default:   st <= SU_IDLE;
      endcase
    end
  end

  assign ff_release = (st != SU_IDLE);
  assign out_en     = (st == SU_OE) || (st == SU_DONE);
  assign done       = (st == SU_DONE);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter logic [31:0] DEVICE_ID = 32'h0A5C_3093,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic [2:0]        mode_pins,
  input  logic              wait_lock_en,
  input  logic              wait_match_en,
  input  logic              pll_lock,
  input  logic              imp_match,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              mem_clr,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [2:0]        cfg_mode,
  output logic              ff_release,
  output logic              out_en,
  output logic              done,
  output logic              err
);
  parse_t      st;
  logic [CW-1:0] idx, total;
  logic [31:0] crc_q, crc_nx;
  logic        parsing, hs, crc_ok;

  assign parsing = st inside {P_WID, P_SYNC, P_ID, P_LEN, P_DATA, P_CRC};
  assign s_ready = prog_n && parsing;
  assign hs      = s_valid && s_ready;
  assign crc_ok  = (st == P_CRC) && hs && (s_data == crc_q);

  cfg_crc_step #(.WW(WORD_W), .POLY(CRC_POLY)) u_crc (
    .crc_in (crc_q),
    .word   (s_data),
    .crc_out(crc_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_CLR;
      idx      <= '0;
      total    <= '0;
      crc_q    <= CRC_INIT;
      cfg_mode <= '0;
    end else if (!prog_n) begin
      st  <= P_CLR;
      idx <= '0;
    end else begin
      case (st)
        P_CLR: begin
          if (idx == CW'(DEPTH - 1)) begin
            st  <= P_MODE;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        P_MODE: begin
          cfg_mode <= mode_pins;
          st       <= P_WID;
        end
        P_WID: if (hs && s_data == WIDTH_PAT) st <= P_SYNC;
        P_SYNC: if (hs && s_data == SYNC_WORD) begin
          st    <= P_ID;
          crc_q <= CRC_INIT;
        end
        P_ID: if (hs) begin
          crc_q <= crc_nx;
          st    <= (s_data == DEVICE_ID) ? P_LEN : P_ERR;
        end
        P_LEN: if (hs) begin
          crc_q <= crc_nx;
          total <= s_data[CW-1:0];
          idx   <= '0;
          if (s_data > 32'(DEPTH)) st <= P_ERR;
          else if (s_data == 32'd0) st <= P_CRC;
          else st <= P_DATA;
        end
        P_DATA: if (hs) begin
          crc_q <= crc_nx;
          idx   <= idx + 1'b1;
          if (idx + 1'b1 == total) st <= P_CRC;
        end
        P_CRC: if (hs) st <= crc_ok ? P_BOOT : P_ERR;
        P_BOOT: st <= P_BOOT;
        P_ERR:  st <= P_ERR;
        default: st <= P_ERR;
      endcase
    end
  end

  assign mem_clr   = prog_n && (st == P_CLR);
  assign mem_we    = hs && (st == P_DATA);
  assign mem_addr  = idx[AW-1:0];
  assign mem_wdata = s_data;
  assign err       = (st == P_ERR);

  cfg_startup u_boot (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (!prog_n),
    .go           (crc_ok),
    .wait_lock_en (wait_lock_en),
    .wait_match_en(wait_match_en),
    .pll_lock     (pll_lock),
    .imp_match    (imp_match),
    .ff_release   (ff_release),
    .out_en       (out_en),
    .done         (done)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_n,
  input logic s_ready,
  input logic mem_we,
  input logic mem_clr,
  input logic ff_release,
  input logic out_en,
  input logic done,
  input logic err
);
  assert_done_needs_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_en && ff_release));
  assert_oe_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(ff_release));
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_n) |=> done);
  assert_done_not_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err && prog_n) |=> err);
  assert_prog_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (!s_ready && !mem_we));
  assert_prog_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (!done && !err && !ff_release));
  assert_clr_we_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_clr && mem_we));
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .s_ready(s_ready),
  .mem_we(mem_we), .mem_clr(mem_clr), .ff_release(ff_release),
  .out_en(out_en), .done(done), .err(err)
);

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int          DEPTH = 16;
  localparam logic [31:0] DEV   = 32'h0A5C_3093;
  localparam logic [31:0] WPAT  = 32'h0000_00BB;
  localparam logic [31:0] SYNCW = 32'hAA99_5566;

  logic clk = 0, rst_n = 0, prog_n = 1;
  logic [2:0] mode_pins = 3'd0;
  logic wait_lock_en = 0, wait_match_en = 0, pll_lock = 0, imp_match = 0;
  logic s_valid = 0;
  logic [31:0] s_data = '0;
  logic s_ready, mem_clr, mem_we, ff_release, out_en, done, err;
  logic [3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [2:0] cfg_mode;

  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  cfg_loader #(.DEPTH(DEPTH), .DEVICE_ID(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_pins(mode_pins),
    .wait_lock_en(wait_lock_en), .wait_match_en(wait_match_en),
    .pll_lock(pll_lock), .imp_match(imp_match), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .mem_clr(mem_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cfg_mode(cfg_mode),
    .ff_release(ff_release), .out_en(out_en), .done(done), .err(err)
  );

  function automatic logic [31:0] bcrc(logic [31:0] c, logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      logic top;
      top = c[31];
      c = c << 1;
      if (top ^ w[i]) c = c ^ 32'h1EDC_6F41;
    end
    return c;
  endfunction

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  // Behavioural reference: phase 0 clear,1 mode,2 width,3 sync,4 id,5 count,
  // 6 data,7 crc,8 release,9 lock wait,10 match wait,11 drivers,12 done,13 error
  int m_ph = 0, m_idx = 0, m_total = 0;
  logic [31:0] m_crc = '1;
  logic [2:0] m_mode = '0;

  always @(posedge clk) begin
    bit rdy, hs;
    rdy = prog_n && m_ph >= 2 && m_ph <= 7;
    hs  = rdy && s_valid;
    if (!rst_n) begin m_ph = 0; m_idx = 0; m_mode = 0; end
    else if (!prog_n) begin m_ph = 0; m_idx = 0; end
    else case (m_ph)
      0: if (m_idx == DEPTH - 1) begin m_ph = 1; m_idx = 0; end else m_idx++;
      1: begin m_mode = mode_pins; m_ph = 2; end
      2: if (hs && s_data == WPAT) m_ph = 3;
      3: if (hs && s_data == SYNCW) begin m_ph = 4; m_crc = '1; end
      4: if (hs) begin m_crc = bcrc(m_crc, s_data); m_ph = (s_data == DEV) ? 5 : 13; end
      5: if (hs) begin
           m_crc = bcrc(m_crc, s_data); m_idx = 0;
           if (s_data > 32'(DEPTH)) m_ph = 13;
           else begin m_total = int'(s_data); m_ph = (m_total == 0) ? 7 : 6; end
         end
      6: if (hs) begin m_crc = bcrc(m_crc, s_data); m_idx++; if (m_idx == m_total) m_ph = 7; end
      7: if (hs) m_ph = (s_data == m_crc) ? 8 : 13;
      8: m_ph = 9;
      9: if (!wait_lock_en || pll_lock) m_ph = 10;
      10: if (!wait_match_en || imp_match) m_ph = 11;
      11: m_ph = 12;
      default: ;
    endcase
  end

  logic [31:0] img [DEPTH];

  always @(negedge clk) begin
    bit er, ew, ec;
    er = prog_n && m_ph >= 2 && m_ph <= 7;
    ew = er && s_valid && m_ph == 6;
    ec = prog_n && m_ph == 0;
    chk("R11 s_ready", 32'(s_ready), 32'(er));
    chk("R5 mem_we", 32'(mem_we), 32'(ew));
    chk("R1 mem_clr", 32'(mem_clr), 32'(ec));
    if (ec || ew) chk("R5 mem_addr", 32'(mem_addr), 32'(m_idx));
    if (ew) chk("R5 mem_wdata", mem_wdata, s_data);
    chk("R8 ff_release", 32'(ff_release), 32'(m_ph >= 8 && m_ph <= 12));
    chk("R9 out_en", 32'(out_en), 32'(m_ph == 11 || m_ph == 12));
    chk("R8 done", 32'(done), 32'(m_ph == 12));
    chk("R4 err", 32'(err), 32'(m_ph == 13));
    chk("R2 cfg_mode", 32'(cfg_mode), 32'(m_mode));
    if (mem_we) img[mem_addr] = mem_wdata;
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(logic [31:0] w, bit gaps);
    if (gaps) repeat ($urandom_range(0, 2)) begin @(posedge clk); #2; end
    s_valid = 1; s_data = w;
    do @(negedge clk); while (!s_ready);
    @(posedge clk); #2;
    s_valid = 0;
  endtask

  task automatic restart();
    prog_n = 0; run(3);
    @(negedge clk);
    chk("R10 done low after program", 32'(done), 0);
    chk("R10 err low after program", 32'(err), 0);
    run(1); prog_n = 1;
  endtask

  // kind: 0 good, 1 bad id, 2 bad crc, 3 count over depth
  task automatic load(int n, int kind, bit gaps);
    logic [31:0] c, id, w;
    id = (kind == 1) ? (DEV ^ 32'h1) : DEV;
    send(32'h1234_5678, gaps);           // ignored before width pattern
    @(negedge clk);
    chk("R3 still waiting for width", 32'(s_ready), 1);
    send(SYNCW, gaps);                   // not the width pattern: ignored
    send(WPAT, gaps);
    send(32'hDEAD_BEEF, gaps);           // ignored before sync
    send(SYNCW, gaps);
    send(id, gaps);
    if (kind == 1) return;
    c = bcrc(32'hFFFF_FFFF, id);
    c = bcrc(c, 32'(n));
    send(32'(n), gaps);
    if (kind == 3) return;
    for (int k = 0; k < n; k++) begin
      w = 32'hC0DE_0000 + 32'(k) + 32'(n << 8);
      c = bcrc(c, w);
      send(w, gaps);
    end
    send((kind == 2) ? (c ^ 32'h1) : c, gaps);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset err", 32'(err), 0);
    chk("R1 reset out_en", 32'(out_en), 0);
    run(3); rst_n = 1;

    // Good frame, mode 5
    mode_pins = 3'd5;
    load(4, 0, 0);
    run(8); @(negedge clk);
    chk("R8 done after good frame", 32'(done), 1);
    chk("R6 no err on good crc", 32'(err), 0);
    for (int k = 0; k < 4; k++)
      chk("R5 memory image", img[k], 32'hC0DE_0000 + 32'(k) + 32'(4 << 8));
    mode_pins = 3'd2; run(2); @(negedge clk);
    chk("R2 mode held", 32'(cfg_mode), 5);

    restart();
    load(2, 1, 0); run(4); @(negedge clk);
    chk("R4 bad id err", 32'(err), 1);
    chk("R4 bad id done", 32'(done), 0);

    restart();
    load(3, 2, 1); run(6); @(negedge clk);
    chk("R6 bad crc err", 32'(err), 1);
    chk("R6 bad crc done", 32'(done), 0);

    restart();
    load(DEPTH + 1, 3, 0); run(4); @(negedge clk);
    chk("R7 count over depth", 32'(err), 1);

    // Waits enabled, full-depth frame with bubbles
    restart();
    mode_pins = 3'd3;
    wait_lock_en = 1; wait_match_en = 1;
    load(DEPTH, 0, 1);
    run(10); @(negedge clk);
    chk("R9 release while waiting", 32'(ff_release), 1);
    chk("R9 drivers held for lock", 32'(out_en), 0);
    pll_lock = 1; run(5); @(negedge clk);
    chk("R9 drivers held for match", 32'(out_en), 0);
    imp_match = 1; run(4); @(negedge clk);
    chk("R9 done after both waits", 32'(done), 1);
    chk("R2 new mode", 32'(cfg_mode), 3);

    // Program request collides with a data handshake
    restart();
    wait_lock_en = 0; wait_match_en = 0;
    send(WPAT, 0); send(SYNCW, 0); send(DEV, 0); send(32'd8, 0);
    send(32'h1, 0); send(32'h2, 0);
    s_valid = 1; s_data = 32'h3; prog_n = 0;
    @(negedge clk);
    chk("R10 ready low on program", 32'(s_ready), 0);
    chk("R10 no write on program", 32'(mem_we), 0);
    run(1); s_valid = 0; run(1); prog_n = 1;
    @(negedge clk);
    chk("R1 clear restarts", 32'(mem_clr), 1);
    load(0, 0, 0); run(8); @(negedge clk);
    chk("R7 zero count reaches done", 32'(done), 1);

    summary();
  end
endmodule